// File: doc/BRIEF.md
# Proximity Measurement Cycle Scheduler

This block sequences repeated proximity readings. Once enabled, it starts an infrared emitter pulse at once, holds it for a fixed number of clock cycles, then waits for the external converter to deliver an 8-bit reading. It latches that reading, raises a one-cycle ready strobe, and then sleeps for an interval selected by a 3-bit code before the next pulse. The interval is counted in ticks of a 0.5 ms timebase supplied from outside. Codes run from back-to-back operation up to 800 ms.

Dropping the enable aborts whatever phase is in progress and turns the emitter off. An aborted measurement never updates the result. A drive-strength bit is sampled at the start of each pulse and forwarded, gated by the pulse, to the analog current sink. The analog sink and the converter sit outside the block.

Top module: `prox_cycle_sched`

## Requirements
- R1: While reset is asserted, emit_o, drive_hi_o and ready_o are 0 and result_o is 0.
- R2: When en_i is sampled high while the block is idle, emit_o is 1 in the very next cycle. No sleep precedes the first measurement.
- R3: Each uninterrupted emitter pulse keeps emit_o high for exactly PULSE_CYC consecutive cycles.
- R4: In the cycle after en_i is sampled low, emit_o and drive_hi_o are 0. A measurement aborted this way produces no ready_o.
- R5: After a pulse ends, the first conv_valid_i sampled high loads conv_data_i into result_o. In the next cycle ready_o is high for exactly one cycle.
- R6: conv_valid_i arriving while idle, pulsing or sleeping is ignored: result_o keeps its value and ready_o stays 0.
- R7: The sleep between the ready strobe and the next emitter rise spans this many tick_i pulses, by code: 3'b000=1600, 3'b001=800, 3'b010=400, 3'b011=200, 3'b100=150, 3'b101=100, 3'b110=25. That is 800/400/200/100/75/50/12.5 ms at 0.5 ms per tick.
- R8: Code 3'b111 means no sleep. emit_o rises in the same cycle in which ready_o is high.
- R9: sleep_code_i is sampled only when a result is captured. Changing it during a sleep does not alter that sleep and applies from the next one.
- R10: drive_hi_o equals drive_hi_i as sampled when the pulse started. It holds that value for the whole pulse and is 0 whenever emit_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sensing enable |
| sleep_code_i | input | 3 | Sleep interval select |
| drive_hi_i | input | 1 | Emitter drive select: 0 standard, 1 doubled |
| tick_i | input | 1 | One-cycle 0.5 ms timebase tick |
| conv_valid_i | input | 1 | Converter result strobe |
| conv_data_i | input | 8 | Converter result |
| emit_o | output | 1 | Emitter pulse enable |
| drive_hi_o | output | 1 | High drive select to the sink, active during the pulse |
| result_o | output | 8 | Last captured proximity result |
| ready_o | output | 1 | One-cycle new-result strobe |

## Verification
A wrong sleep count or a mis-decoded code shows up as a tick count between the ready strobe and the next emitter rise that differs from the table. This is visible within one sleep interval, or at the first pulse for back-to-back mode. A corrupted pulse counter shows up as a pulse width other than PULSE_CYC on the very first measurement. A stuck or wrong phase shows up within a cycle: the emitter stays lit after disable, a stray ready appears on an out-of-phase converter strobe, or the result changes without ready.

// File: rtl/prox_sched_pkg.sv
package prox_sched_pkg;
  localparam int unsigned SLP_W = 11;
  localparam int unsigned RES_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SLEEP
  } sched_st_e;

  // sleep length in 0.5 ms ticks
  localparam logic [SLP_W-1:0] SLP_800MS = SLP_W'(1600);
  localparam logic [SLP_W-1:0] SLP_400MS = SLP_W'(800);
  localparam logic [SLP_W-1:0] SLP_200MS = SLP_W'(400);
  localparam logic [SLP_W-1:0] SLP_100MS = SLP_W'(200);
  localparam logic [SLP_W-1:0] SLP_75MS  = SLP_W'(150);
  localparam logic [SLP_W-1:0] SLP_50MS  = SLP_W'(100);
  localparam logic [SLP_W-1:0] SLP_12MS5 = SLP_W'(25);
endpackage

// File: rtl/prox_sleep_lut.sv
module prox_sleep_lut
  import prox_sched_pkg::*;
(
  input  logic [2:0]       code_i,
  output logic [SLP_W-1:0] ticks_o
);
  always_comb begin
    unique case (code_i)
      3'b000:  ticks_o = SLP_800MS;
      3'b001:  ticks_o = SLP_400MS;
      3'b010:  ticks_o = SLP_200MS;
      3'b011:  ticks_o = SLP_100MS;
      3'b100:  ticks_o = SLP_75MS;
      3'b101:  ticks_o = SLP_50MS;
      3'b110:  ticks_o = SLP_12MS5;
      default: ticks_o = '0;
    endcase
  end
endmodule

// File: rtl/prox_down_cnt.sv
module prox_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  // counter saturates at zero instead of wrapping
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/prox_cycle_sched.sv
module prox_cycle_sched
  import prox_sched_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 25000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       sleep_code_i,
  input  logic             drive_hi_i,
  input  logic             tick_i,
  input  logic             conv_valid_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             emit_o,
  output logic             drive_hi_o,
  output logic [RES_W-1:0] result_o,
  output logic             ready_o
);
  localparam int unsigned PCW = $clog2(PULSE_CYC + 1);
  localparam logic [PCW-1:0] PULSE_LAST = PCW'(PULSE_CYC - 1);

  sched_st_e        st_q, st_d;
  logic             pulse_ld, slp_ld, capture;
  logic [PCW-1:0]   pulse_cnt;
  logic [SLP_W-1:0] slp_cnt, slp_ticks;
  logic [RES_W-1:0] result_q;
  logic             ready_q, drive_q;

  prox_sleep_lut u_lut (
    .code_i  (sleep_code_i),
    .ticks_o (slp_ticks)
  );

  prox_down_cnt #(.W(PCW)) u_pulse_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (pulse_ld),
    .load_val_i (PULSE_LAST),
    .dec_i      (st_q == ST_PULSE),
    .cnt_o      (pulse_cnt)
  );

  prox_down_cnt #(.W(SLP_W)) u_sleep_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (slp_ld),
    .load_val_i (slp_ticks),
    .dec_i      ((st_q == ST_SLEEP) && tick_i),
    .cnt_o      (slp_cnt)
  );

  assign capture = en_i && (st_q == ST_WAIT) && conv_valid_i;

  always_comb begin
    st_d     = st_q;
    pulse_ld = 1'b0;
    slp_ld   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_d     = ST_PULSE;
        pulse_ld = 1'b1;
      end
      ST_PULSE: if (pulse_cnt == '0) st_d = ST_WAIT;
      ST_WAIT: if (conv_valid_i) begin
        slp_ld = 1'b1;
        if (slp_ticks == '0) begin
          st_d     = ST_PULSE;
          pulse_ld = 1'b1;
        end else begin
          st_d = ST_SLEEP;
        end
      end
      ST_SLEEP: if (tick_i && slp_cnt == SLP_W'(1)) begin
        st_d     = ST_PULSE;
        pulse_ld = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (!en_i) begin
      st_d     = ST_IDLE;
      pulse_ld = 1'b0;
      slp_ld   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      result_q <= '0;
      ready_q  <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_q <= capture;
      if (capture)  result_q <= conv_data_i;
      if (pulse_ld) drive_q  <= drive_hi_i;
    end
  end

  assign emit_o     = (st_q == ST_PULSE);
  assign drive_hi_o = emit_o && drive_q;
  assign result_o   = result_q;
  assign ready_o    = ready_q;

  p_start_now_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && en_i) |=> emit_o);

  p_off_when_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!emit_o && !drive_hi_o));

  p_ready_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(conv_valid_i));

  p_ready_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> ready_o);

  p_sleep_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SLEEP && en_i && !tick_i) |=> $stable(slp_cnt));

  p_drive_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_hi_o |-> emit_o);
endmodule

// File: tb/sim_prox_cycle_sched.sv
`timescale 1ns/1ps
module sim_prox_cycle_sched;
  localparam int PULSE = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [2:0] code = 3'b000;
  logic       drv = 1'b0;
  logic       tick_q = 1'b0;
  logic       cv_q = 1'b0;
  logic [7:0] cd_q = 8'h00;
  logic       emit, drv_o, rdy;
  logic [7:0] res;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  prox_cycle_sched #(.PULSE_CYC(PULSE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sleep_code_i(code),
    .drive_hi_i(drv), .tick_i(tick_q), .conv_valid_i(cv_q), .conv_data_i(cd_q),
    .emit_o(emit), .drive_hi_o(drv_o), .result_o(res), .ready_o(rdy)
  );

  function automatic int exp_ticks(input logic [2:0] c);
    case (c)
      3'b000: return 1600;
      3'b001: return 800;
      3'b010: return 400;
      3'b011: return 200;
      3'b100: return 150;
      3'b101: return 100;
      3'b110: return 25;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor plus timebase: one process, so tick sampling has no race
  int  rdy_cnt = 0, gap_seq = -1, gap_start = 0, gap_acc = 0, last_gap = 0;
  int  pw_acc = 0, last_pw = 0, pw_seen = 0, tdiv = 0;
  bit  counting = 0, emit_prev = 0;
  always @(negedge clk) begin
    if (counting) begin
      gap_acc += int'(tick_q);
      if (emit) begin last_gap = gap_acc; gap_seq = gap_start; counting = 0; end
    end
    if (emit) pw_acc++;
    else if (emit_prev) begin last_pw = pw_acc; pw_acc = 0; pw_seen++; end
    if (rdy) begin
      if (emit) begin last_gap = 0; gap_seq = rdy_cnt + 1; counting = 0; end
      else begin counting = 1; gap_acc = 0; gap_start = rdy_cnt + 1; end
      rdy_cnt++;
    end
    emit_prev = emit;
    tdiv   = (tdiv == 3) ? 0 : tdiv + 1;
    tick_q = (tdiv == 0);
  end

  // converter stub
  bit       man_req = 0, stub_prev = 0;
  logic [7:0] man_data = 8'h00, seq = 8'h11, sent = 8'h00;
  int       lat = 0;
  always @(negedge clk) begin
    cv_q = 1'b0;
    if (man_req) begin
      cv_q = 1'b1; cd_q = man_data; man_req = 0;
    end else if (lat != 0) begin
      lat--;
      if (lat == 0) begin cv_q = 1'b1; cd_q = seq; sent = seq; seq = seq + 8'd37; end
    end
    if (stub_prev && !emit) lat = 3;
    stub_prev = emit;
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    cycles(2);
    chk(emit == 0, "R1 emit", emit, 0);
    chk(drv_o == 0, "R1 drive", drv_o, 0);
    chk(rdy == 0, "R1 ready", rdy, 0);
    chk(res == 0, "R1 result", res, 0);
    rst_n = 1'b1;
    cycles(2);
  endtask

  task automatic t_first;
    int c0, p0;
    logic [7:0] r0;
    code = 3'b000; drv = 1'b0;
    c0 = rdy_cnt; p0 = pw_seen;
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk(emit == 1, "R2 first pulse immediate", emit, 1);
    wait (pw_seen != p0);
    chk(last_pw == PULSE, "R3 pulse width", last_pw, PULSE);
    wait (rdy_cnt != c0);
    chk(res == sent, "R5 result captured", res, sent);
    @(negedge clk);
    chk(rdy == 0, "R5 ready one cycle", rdy, 0);
    // now sleeping: stray converter strobe must be ignored (R6)
    r0 = res; c0 = rdy_cnt;
    @(posedge clk) begin man_data = 8'hA5; man_req = 1; end
    cycles(6);
    chk(rdy_cnt == c0, "R6 no ready in sleep", rdy_cnt, c0);
    chk(res == r0, "R6 result kept in sleep", res, r0);
    en = 1'b0;
    @(negedge clk);
    chk(emit == 0, "R4 off after disable", emit, 0);
    cycles(10);
  endtask

  task automatic t_codes;
    int c0, r;
    en = 1'b1;
    for (int k = 7; k >= 0; k--) begin
      code = 3'(k);
      c0 = rdy_cnt;
      wait (rdy_cnt != c0);
      r = rdy_cnt;
      wait (gap_seq == r);
      if (k == 7) chk(last_gap == 0, "R8 back-to-back", last_gap, 0);
      else chk(last_gap == exp_ticks(3'(k)), "R7 sleep ticks", last_gap, exp_ticks(3'(k)));
    end
    @(negedge clk) en = 1'b0;
    cycles(10);
  endtask

  task automatic t_midchange;
    int c0, r;
    code = 3'b100;
    c0 = rdy_cnt;
    @(negedge clk) en = 1'b1;
    wait (rdy_cnt != c0);
    r = rdy_cnt;
    cycles(20);
    code = 3'b111;
    wait (gap_seq == r);
    chk(last_gap == 150, "R9 sleep unchanged by mid change", last_gap, 150);
    c0 = rdy_cnt;
    wait (rdy_cnt != c0);
    r = rdy_cnt;
    wait (gap_seq == r);
    chk(last_gap == 0, "R9 new code next sleep", last_gap, 0);
    @(negedge clk) en = 1'b0;
    cycles(10);
  endtask

  task automatic t_abort;
    int c0;
    logic [7:0] r0;
    code = 3'b000;
    @(negedge clk) en = 1'b1;
    cycles(5);
    chk(emit == 1, "R4 pulse running", emit, 1);
    c0 = rdy_cnt; r0 = res;
    en = 1'b0;
    @(negedge clk);
    chk(emit == 0 && drv_o == 0, "R4 abort kills emitter", emit, 0);
    cycles(40);
    chk(rdy_cnt == c0, "R4 no ready after abort", rdy_cnt, c0);
    chk(res == r0, "R6 result kept after abort", res, r0);
  endtask

  task automatic t_drive;
    int p0;
    code = 3'b000;
    drv = 1'b1;
    p0 = pw_seen;
    @(negedge clk) en = 1'b1;
    @(negedge clk);
    chk(drv_o == 1, "R10 high drive in pulse", drv_o, 1);
    cycles(3);
    drv = 1'b0;
    cycles(3);
    chk(drv_o == 1, "R10 drive held for pulse", drv_o, 1);
    wait (pw_seen != p0);
    @(negedge clk);
    chk(drv_o == 0, "R10 drive off outside pulse", drv_o, 0);
    en = 1'b0;
    cycles(5);
  endtask

  initial begin
    t_reset;
    t_first;
    t_codes;
    t_midchange;
    t_abort;
    t_drive;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule